// File: doc/BRIEF.md
# Six-Bit Calculator ALU

This block is the arithmetic and logic core of a small integer calculator. It takes two 6-bit operands, `a_i` and `b_i`, and a 3-bit operation code. It returns a 6-bit result together with three status flags. Operands and results are two's-complement numbers in the range -32 to +31. Arithmetic wraps modulo 64, so 64 is the same as 0.

The block has no clock and no storage, so every output follows its inputs within the same cycle. All arithmetic goes through a single adder. Addition feeds the operands to the adder unchanged. Subtraction inverts the second operand and forces the carry into bit 0 to 1. Negation does the same with the first adder input held at zero. Overflow is judged from the signs of the operands that actually reach the adder. Overflow applies to arithmetic codes only.

Top module: `calc_alu`

## Requirements
- R1: With op code 000 the result is (A + B) mod 64.
- R2: With op code 001 the result is (A - B) mod 64, formed as A + ~B + 1.
- R3: Op codes 010, 011 and 111 give the bitwise AND, OR and XOR of A and B respectively.
- R4: Op code 100 gives 000001 when A equals B and 000000 otherwise.
- R5: Op code 101 gives the bitwise inverse of B.
- R6: Op code 110 gives the two's-complement negation of B, that is ~B + 1 modulo 64.
- R7: For op code 000, the overflow flag is 1 exactly when the signed sum of A and B lies outside -32..31 (for example 31 + 31).
- R8: For op code 001, the overflow flag is 1 exactly when the signed difference A - B lies outside -32..31.
- R9: For op code 110, the overflow flag is 1 only when B is 100000 (-32).
- R10: For op codes 010, 011, 100, 101 and 111, the overflow flag is 0.
- R11: The negative flag equals bit 5 of the result for every op code.
- R12: The zero flag is 1 exactly when all six result bits are 0, for every op code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 6 | First operand, two's complement |
| b_i | input | 6 | Second operand, two's complement |
| op_i | input | 3 | Operation code |
| c_o | output | 6 | Result |
| ovf_o | output | 1 | Signed overflow of an arithmetic code |
| neg_o | output | 1 | Result sign bit |
| zero_o | output | 1 | Result is all zeros |

## Verification
The block holds no state, so any fault in the operand inversion, the carry injection or the sign rule appears at once on `c_o` or `ovf_o` for the input combination that exercises it. A carry forced in the wrong case shifts the result by one. Gating overflow on the wrong code shows up as a spurious or missing flag, and that happens at operand boundaries such as 31, -32 and -1. The sweep applies all 64 x 64 x 8 input combinations, so each such fault is exposed in the first cycle that presents a triggering vector.

// File: rtl/calc_alu.sv
module calc_alu #(
  parameter int W = 6
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   op_i,
  output logic [W-1:0] c_o,
  output logic         ovf_o,
  output logic         neg_o,
  output logic         zero_o
);

  localparam logic [2:0] OP_ADD  = 3'd0;
  localparam logic [2:0] OP_SUB  = 3'd1;
  localparam logic [2:0] OP_AND  = 3'd2;
  localparam logic [2:0] OP_OR   = 3'd3;
  localparam logic [2:0] OP_EQ   = 3'd4;
  localparam logic [2:0] OP_NOTB = 3'd5;
  localparam logic [2:0] OP_NEGB = 3'd6;
  localparam logic [2:0] OP_XOR  = 3'd7;
  localparam int         MSB     = W - 1;

  logic         is_arith;
  logic         inv_b;
  logic [W-1:0] add_a;
  logic [W-1:0] add_b;
  logic [W-1:0] sum;
  logic         add_ovf;

  assign is_arith = (op_i == OP_ADD) || (op_i == OP_SUB) || (op_i == OP_NEGB);
  assign inv_b    = (op_i == OP_SUB) || (op_i == OP_NEGB);
  assign add_a    = (op_i == OP_NEGB) ? '0 : a_i;
  assign add_b    = inv_b ? ~b_i : b_i;
  assign sum      = add_a + add_b + {{(W-1){1'b0}}, inv_b};
  assign add_ovf  = (add_a[MSB] == add_b[MSB]) && (sum[MSB] != add_a[MSB]);

  always_comb begin
    case (op_i)
      OP_AND:  c_o = a_i & b_i;
      OP_OR:   c_o = a_i | b_i;
      OP_EQ:   c_o = {{(W-1){1'b0}}, (a_i == b_i)};
      OP_NOTB: c_o = ~b_i;
      OP_XOR:  c_o = a_i ^ b_i;
      default: c_o = sum;
    endcase
  end

  assign ovf_o  = is_arith & add_ovf;
  assign neg_o  = c_o[MSB];
  assign zero_o = ~|c_o;

  always_comb begin
    // R4
    eq_shape_chk: assert ((op_i != OP_EQ) || (c_o[W-1:1] == '0));
    // R5
    notb_chk: assert ((op_i != OP_NOTB) || ((c_o ^ b_i) == {W{1'b1}}));
    // R6
    negb_chk: assert ((op_i != OP_NEGB) || (W'(c_o + b_i) == '0));
    // R2
    sub_self_chk: assert ((op_i != OP_SUB) || (a_i != b_i) || zero_o);
    // R7
    add_mixed_sign_chk: assert ((op_i != OP_ADD) || (a_i[MSB] == b_i[MSB]) || !ovf_o);
    // R10
    no_overflow_chk: assert (is_arith || !ovf_o);
  end

endmodule

// File: tb/tb_calc_alu.sv
module tb_calc_alu;
  logic       clk = 1'b0;
  logic [5:0] a, b;
  logic [2:0] op;
  logic [5:0] c;
  logic       ovf, neg, zero;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  calc_alu #(.W(6)) dut (
    .a_i(a), .b_i(b), .op_i(op),
    .c_o(c), .ovf_o(ovf), .neg_o(neg), .zero_o(zero)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s a=%0d b=%0d op=%0d actual=%0d expected=%0d", req, a, b, op, act, exp);
    end
  endtask

  function automatic int sval(input int u);
    return (u >= 32) ? u - 64 : u;
  endfunction

  function automatic int wrap(input int v);
    return ((v % 64) + 64) % 64;
  endfunction

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    a = '0; b = '0; op = 3'd0;
    @(negedge clk); #1;
    chk("R1 initial", c, 0);
    chk("R12 initial", zero, 1);
    for (int o = 0; o < 8; o++) begin
      for (int ia = 0; ia < 64; ia++) begin
        for (int ib = 0; ib < 64; ib++) begin
          int ec, full, eo;
          string rq, ro;
          @(negedge clk);
          a = 6'(ia); b = 6'(ib); op = 3'(o);
          #2;
          eo = 0;
          case (o)
            0: begin full = sval(ia) + sval(ib); ec = wrap(full);
                     eo = (full > 31 || full < -32) ? 1 : 0; rq = "R1"; ro = "R7"; end
            1: begin full = sval(ia) - sval(ib); ec = wrap(full);
                     eo = (full > 31 || full < -32) ? 1 : 0; rq = "R2"; ro = "R8"; end
            2: begin ec = ia & ib; rq = "R3 and"; ro = "R10"; end
            3: begin ec = ia | ib; rq = "R3 or"; ro = "R10"; end
            4: begin ec = (ia == ib) ? 1 : 0; rq = "R4"; ro = "R10"; end
            5: begin ec = 63 - ib; rq = "R5"; ro = "R10"; end
            6: begin full = -sval(ib); ec = wrap(full);
                     eo = (ib == 32) ? 1 : 0; rq = "R6"; ro = "R9"; end
            default: begin ec = ia ^ ib; rq = "R3 xor"; ro = "R10"; end
          endcase
          chk(rq, c, ec);
          chk(ro, ovf, eo);
          chk("R11", neg, (ec >= 32) ? 1 : 0);
          chk("R12", zero, (ec == 0) ? 1 : 0);
        end
      end
    end
    a = 6'd31; b = 6'd31; op = 3'd0; #2;
    chk("R7 31+31 result", c, 62);
    chk("R7 31+31 flag", ovf, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule